// File: doc/BRIEF.md
# Full-Duplex Serial Port with Flagged Register Window

This block is a full-duplex asynchronous serial port with a byte-wide register window for a host processor. It has two addresses. The data address leads to two separate storage elements. A bus write fills a transmit holding register, and a bus read returns the receive buffer. The status address reports five flags: receive complete, transmit complete, holding register empty, framing error and overrun. Each flag has its own set and clear conditions.

The serial format is fixed: one start bit, eight data bits sent least significant bit first, and one stop bit. The bit time is set by the `CLK_DIV` parameter. The receiver oversamples each bit 16 times and takes a majority vote of three samples around the middle of the bit.

Two level interrupt requests drive an interrupt controller. Each is gated by its own enable input. The controller can clear the transmit-complete flag through an acknowledge pulse.

Top module: `uart_flagged`

## Requirements
- R1: After reset, a status read returns 8'h20 (only the empty flag, bit 5, is set), `tx_out` is high, and both interrupt outputs are low.
- R2: A byte written at data address (`bus_addr`=0) is sent on `tx_out` as a low start bit, then 8 data bits least significant bit first, then a high stop bit. Each bit lasts 16*`CLK_DIV` clocks.
- R3: A character received on `rx_in` is placed in the receive buffer, and receive complete (status bit 7) sets. A data-address read returns that byte.
- R4: A read at the data address clears receive complete. `rx_irq` is high exactly when receive complete and `rx_ie` are both high.
- R5: Transmit complete (bit 6) sets once a stop bit has finished and the holding register is empty. It stays low between back-to-back frames.
- R6: Transmit complete clears on a `tx_acq` pulse or on a status-address write (`bus_addr`=1) with bit 6 set. `tx_irq` is high exactly when transmit complete and `tx_ie` are both high.
- R7: The empty flag (bit 5) drops on an accepted data write and rises when the held byte moves into the shifter. A data write while the flag is low is ignored.
- R8: Framing error (bit 4) is captured when the stop bit is sampled low. Receive complete still sets, and the byte is kept. The flag stays with the buffered byte until the next character is stored.
- R9: Overrun (bit 3) sets when a character completes while receive complete is still set. That new character is discarded. Overrun clears when the next character is stored.
- R10: A low pulse on `rx_in` shorter than half a bit is rejected as a start bit, and no character is produced.
- R11: Status bits 2 to 0 read as zero. `bus_rdata` presents the selected register on the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects data, 1 selects status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| tx_ack | input | 1 | Transmit interrupt acknowledge |
| rx_in | input | 1 | Serial input |
| tx_out | output | 1 | Serial output |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
All 256 byte values are transmitted. At the same time, each value XOR 8'h3C is received, so every bit position sees both levels in both directions and a swapped bit order or a shared buffer would show up. Sweep iterations alternate between the acknowledge pulse and the write-one path to clear transmit complete, so either path failing is caught. Directed sequences cover three holding-register cases: a back-to-back transmission, a third write made while the holding register is full, and the status read between the two frames. Further sequences send a frame with a low stop bit, receive two characters with no read between them, and drive a short low glitch on the line; each separates one flag's set rule from its clear rule.

// File: rtl/uart_flagged_pkg.sv
package uart_flagged_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OVS = 16;
  localparam int unsigned OVS_W = $clog2(OVS);
  localparam int unsigned ST_RXC = 7;
  localparam int unsigned ST_TXC = 6;
  localparam int unsigned ST_EMPTY = 5;
  localparam int unsigned ST_FE = 4;
  localparam int unsigned ST_OVR = 3;

  typedef enum logic [1:0] {
    TX_IDLE, TX_START, TX_DATA, TX_STOP
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_t;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int unsigned CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= (cnt_q == LAST);
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_flagged_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              busy,
  output logic              done,
  output logic              txd
);
  localparam logic [OVS_W-1:0] TLAST = OVS_W'(OVS - 1);
  localparam int unsigned IW = $clog2(BYTE_W);
  localparam logic [IW-1:0] ILAST = IW'(BYTE_W - 1);

  tx_state_t         state_q;
  logic [OVS_W-1:0]  tcnt_q;
  logic [IW-1:0]     idx_q;
  logic [BYTE_W-1:0] sh_q;

  assign busy = (state_q != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      txd     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state_q == TX_IDLE) begin
        if (load) begin
          sh_q    <= load_data;
          state_q <= TX_START;
          tcnt_q  <= '0;
          idx_q   <= '0;
          txd     <= 1'b0;
        end
      end else if (tick) begin
        if (tcnt_q != TLAST) begin
          tcnt_q <= tcnt_q + 1'b1;
        end else begin
          tcnt_q <= '0;
          case (state_q)
            TX_START: begin
              state_q <= TX_DATA;
              txd     <= sh_q[0];
            end
            TX_DATA: begin
              sh_q <= sh_q >> 1;
              if (idx_q == ILAST) begin
                state_q <= TX_STOP;
                txd     <= 1'b1;
              end else begin
                idx_q <= idx_q + 1'b1;
                txd   <= sh_q[1];
              end
            end
            default: begin
              state_q <= TX_IDLE;
              done    <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_flagged_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              ferr
);
  localparam logic [OVS_W-1:0] TLAST = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] S_LO = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] S_HI = OVS_W'(OVS / 2 + 1);
  localparam logic [OVS_W-1:0] STOP_END = OVS_W'(OVS / 2 + 2);
  localparam int unsigned IW = $clog2(BYTE_W);
  localparam logic [IW-1:0] ILAST = IW'(BYTE_W - 1);

  rx_state_t         state_q;
  logic [1:0]        sync_q;
  logic [OVS_W-1:0]  tcnt_q;
  logic [IW-1:0]     idx_q;
  logic [2:0]        smp_q;
  logic [BYTE_W-1:0] sh_q;
  logic              vote;

  assign vote = (smp_q[0] & smp_q[1]) | (smp_q[1] & smp_q[2]) | (smp_q[0] & smp_q[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      sh_q    <= '0;
      done    <= 1'b0;
      data    <= '0;
      ferr    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      done   <= 1'b0;
      if (tick) begin
        if (state_q == RX_IDLE) begin
          if (!sync_q[1]) begin
            state_q <= RX_START;
            tcnt_q  <= '0;
          end
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
          if (tcnt_q >= S_LO && tcnt_q <= S_HI) smp_q <= {smp_q[1:0], sync_q[1]};
          case (state_q)
            RX_START: if (tcnt_q == TLAST) begin
              if (vote) state_q <= RX_IDLE;
              else begin
                state_q <= RX_DATA;
                idx_q   <= '0;
              end
            end
            RX_DATA: if (tcnt_q == TLAST) begin
              sh_q <= {vote, sh_q[BYTE_W-1:1]};
              if (idx_q == ILAST) state_q <= RX_STOP;
              else                idx_q <= idx_q + 1'b1;
            end
            default: if (tcnt_q == STOP_END) begin
              state_q <= RX_IDLE;
              done    <= 1'b1;
              data    <= sh_q;
              ferr    <= ~vote;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_flagged.sv
module uart_flagged
  import uart_flagged_pkg::*;
#(
  parameter int unsigned CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rx_ie,
  input  logic              tx_ie,
  input  logic              tx_ack,
  input  logic              rx_in,
  output logic              tx_out,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic              tick;
  logic              tx_busy, tx_done, tx_load;
  logic              rx_done, rx_ferr;
  logic [BYTE_W-1:0] rx_data;

  logic [BYTE_W-1:0] thr_q, rbuf_q;
  logic              thr_full, txc_q, rxc_q, fe_q, ovr_q;
  logic [BYTE_W-1:0] status;
  logic              wr_data, wr_stat, rd_data;

  assign wr_data = bus_wr & ~bus_addr;
  assign wr_stat = bus_wr & bus_addr;
  assign rd_data = bus_rd & ~bus_addr;
  assign tx_load = thr_full & ~tx_busy;

  always_comb begin
    status           = '0;
    status[ST_RXC]   = rxc_q;
    status[ST_TXC]   = txc_q;
    status[ST_EMPTY] = ~thr_full;
    status[ST_FE]    = fe_q;
    status[ST_OVR]   = ovr_q;
  end

  uart_tick_gen #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  uart_tx_engine tx_i (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_load), .load_data(thr_q),
    .busy(tx_busy), .done(tx_done), .txd(tx_out)
  );

  uart_rx_engine rx_i (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rx_in),
    .done(rx_done), .data(rx_data), .ferr(rx_ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q     <= '0;
      thr_full  <= 1'b0;
      txc_q     <= 1'b0;
    end else begin
      if (tx_load) thr_full <= 1'b0;
      else if (wr_data && !thr_full) begin
        thr_q    <= bus_wdata;
        thr_full <= 1'b1;
      end
      if (tx_done && !thr_full)                      txc_q <= 1'b1;
      else if (tx_ack || (wr_stat && bus_wdata[ST_TXC])) txc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbuf_q <= '0;
      rxc_q  <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (rx_done) begin
      if (rxc_q) ovr_q <= 1'b1;
      else begin
        rbuf_q <= rx_data;
        fe_q   <= rx_ferr;
        rxc_q  <= 1'b1;
        ovr_q  <= 1'b0;
      end
    end else if (rd_data) begin
      rxc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= bus_addr ? status : rbuf_q;
  end

  assign rx_irq = rxc_q & rx_ie;
  assign tx_irq = txc_q & tx_ie;
endmodule

// File: rtl/uart_flagged_chk.sv
module uart_flagged_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       rx_ie,
  input logic       tx_ie,
  input logic       tx_ack,
  input logic       rx_irq,
  input logic       tx_irq,
  input logic       rxc_q,
  input logic       txc_q,
  input logic       thr_full,
  input logic [7:0] thr_q,
  input logic [7:0] rbuf_q,
  input logic       ovr_q,
  input logic       rx_done,
  input logic       tx_done
);
  // R4
  rxc_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr && !rx_done) |=> !rxc_q);
  // R4
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (rx_ie && rxc_q));
  // R6
  txc_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ack && !tx_done) |=> !txc_q);
  // R6
  tx_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (tx_ie && txc_q));
  // R7
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && thr_full) |=> $stable(thr_q));
  // R9
  overrun_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rxc_q) |=> (ovr_q && $stable(rbuf_q)));
  // R11
  status_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr) |=> (bus_rdata[2:0] == 3'b000));
endmodule

bind uart_flagged uart_flagged_chk chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .rx_ie(rx_ie), .tx_ie(tx_ie), .tx_ack(tx_ack),
  .rx_irq(rx_irq), .tx_irq(tx_irq), .rxc_q(rxc_q), .txc_q(txc_q),
  .thr_full(thr_full), .thr_q(thr_q), .rbuf_q(rbuf_q), .ovr_q(ovr_q),
  .rx_done(rx_done), .tx_done(tx_done)
);

// File: tb/uart_flagged_tb_top.sv
module uart_flagged_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rx_ie = 1'b0, tx_ie = 1'b0, tx_ack = 1'b0, rx_in = 1'b1;
  logic tx_out, rx_irq, tx_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_flagged #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .tx_ack(tx_ack), .rx_in(rx_in), .tx_out(tx_out), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] v, input logic stopv);
    @(negedge clk);
    rx_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = v[i];
      repeat (BIT) @(negedge clk);
    end
    rx_in = stopv;
    repeat (BIT) @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic cap_tx(output logic [7:0] v, output logic stp);
    while (tx_out) @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      v[i] = tx_out;
    end
    repeat (BIT) @(negedge clk);
    stp = tx_out;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  initial begin
    logic [7:0] r, g1, g2;
    logic s1, s2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(tx_out === 1'b1, "R1 tx idle", {7'b0, tx_out}, 8'h01);
    chk(rx_irq === 1'b0 && tx_irq === 1'b0, "R1 irqs", {6'b0, rx_irq, tx_irq}, 8'h00);
    bus_read(1'b1, r);
    chk(r === 8'h20, "R1 status", r, 8'h20);
    chk(r[2:0] === 3'b000, "R11 low bits", r, 8'h20);

    // R2 R3 R4 R5 R6 full-duplex sweep over every byte value
    for (int v = 0; v < 256; v++) begin
      bus_write(1'b0, 8'(v));
      fork
        cap_tx(g1, s1);
        send_rx(8'(v) ^ 8'h3C, 1'b1);
      join
      repeat (BIT) @(negedge clk);
      chk(g1 === 8'(v), "R2 tx byte", g1, 8'(v));
      chk(s1 === 1'b1, "R2 stop bit", {7'b0, s1}, 8'h01);
      bus_read(1'b1, r);
      chk(r === 8'hE0, "R3 R5 status after frames", r, 8'hE0);
      bus_read(1'b0, r);
      chk(r === (8'(v) ^ 8'h3C), "R3 rx byte", r, 8'(v) ^ 8'h3C);
      bus_read(1'b1, r);
      chk(r === 8'h60, "R4 rxc cleared by read", r, 8'h60);
      if (v[0]) begin
        @(negedge clk); tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
      end else begin
        bus_write(1'b1, 8'h40);
      end
      bus_read(1'b1, r);
      chk(r === 8'h20, "R6 txc cleared", r, 8'h20);
    end

    // R5 R7 back-to-back with a write to a full holding register
    bus_write(1'b0, 8'h11);
    bus_write(1'b0, 8'h22);
    bus_read(1'b1, r);
    chk(r === 8'h00, "R7 empty low while held", r, 8'h00);
    bus_write(1'b0, 8'h33);
    fork
      begin cap_tx(g1, s1); cap_tx(g2, s2); end
      begin
        repeat (BIT * 13) @(negedge clk);
        bus_read(1'b1, r);
        chk(r === 8'h20, "R5 no txc between frames", r, 8'h20);
      end
    join
    chk(g1 === 8'h11, "R7 first frame", g1, 8'h11);
    chk(g2 === 8'h22, "R7 held frame kept", g2, 8'h22);
    repeat (BIT) @(negedge clk);
    chk(tx_out === 1'b1, "R7 ignored write not sent", {7'b0, tx_out}, 8'h01);
    bus_read(1'b1, r);
    chk(r === 8'h60, "R5 txc after last frame", r, 8'h60);
    tx_ie = 1'b1;
    @(negedge clk);
    chk(tx_irq === 1'b1, "R6 tx_irq raised", {7'b0, tx_irq}, 8'h01);
    tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0; @(negedge clk);
    chk(tx_irq === 1'b0, "R6 tx_irq cleared by ack", {7'b0, tx_irq}, 8'h00);
    tx_ie = 1'b0;

    // R8 framing error
    send_rx(8'h5A, 1'b0);
    repeat (BIT * 2) @(negedge clk);
    bus_read(1'b1, r);
    chk(r === 8'hB0, "R8 fe with rxc", r, 8'hB0);
    bus_read(1'b0, r);
    chk(r === 8'h5A, "R8 byte kept", r, 8'h5A);
    bus_read(1'b1, r);
    chk(r === 8'h30, "R8 fe stays with buffer", r, 8'h30);

    // R9 overrun
    send_rx(8'h01, 1'b1);
    repeat (BIT) @(negedge clk);
    send_rx(8'h02, 1'b1);
    repeat (BIT) @(negedge clk);
    bus_read(1'b1, r);
    chk(r === 8'hA8, "R9 overrun set", r, 8'hA8);
    bus_read(1'b0, r);
    chk(r === 8'h01, "R9 second char dropped", r, 8'h01);
    bus_read(1'b1, r);
    chk(r === 8'h28, "R9 overrun held", r, 8'h28);
    rx_ie = 1'b1;
    send_rx(8'h03, 1'b1);
    repeat (BIT) @(negedge clk);
    chk(rx_irq === 1'b1, "R4 rx_irq raised", {7'b0, rx_irq}, 8'h01);
    bus_read(1'b1, r);
    chk(r === 8'hA0, "R9 overrun cleared", r, 8'hA0);
    bus_read(1'b0, r);
    chk(r === 8'h03, "R9 next char stored", r, 8'h03);
    @(negedge clk);
    chk(rx_irq === 1'b0, "R4 rx_irq cleared by read", {7'b0, rx_irq}, 8'h00);

    // R10 short start glitch
    @(negedge clk);
    rx_in = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    rx_in = 1'b1;
    repeat (BIT * 12) @(negedge clk);
    bus_read(1'b1, r);
    chk(r === 8'h20, "R10 glitch rejected", r, 8'h20);
    chk(rx_irq === 1'b0, "R10 no irq", {7'b0, rx_irq}, 8'h00);

    finished = 1;
    summary();
  end
endmodule